// File: doc/BRIEF.md
# Single-Cycle Fully Associative Address Translation Cache

This block is a small translation cache placed in front of a cache. On each request it compares a 32-bit virtual address against every stored entry at once. One clock later it reports either a hit, with the physical address, or a miss. A miss raises a refill request that carries the virtual address. Each entry holds a page size, an address-space tag with a global flag, a secure/non-secure tag and three permission bits. The entry that hits is checked against the kind of access, and a violation raises an abort. The abort is of the prefetch kind on an instruction-side build and of the data kind on a data-side build.

A larger backing translation store refills entries through a write port. The block chooses the slot to write: an empty slot first, otherwise the next slot in round-robin order. The whole array is emptied when the context register is written or when the backing store reports a maintenance operation. Software must keep at most one entry matching any request. If several entries do match, the block uses the lowest-numbered one and the checker flags the condition.

Top module: `utlb_top`

## Requirements
- R1: The result of a request on `lk_valid_i` appears on the next clock as exactly one of `hit_o` or `miss_o`. With no request, both are 0 on the next clock, and both are 0 after reset.
- R2: An entry matches only on virtual address bits [31:N]. The 2-bit size code gives N: 0 is 4 KB (N=12), 1 is 64 KB (N=16), 2 is 1 MB (N=20) and 3 is 16 MB (N=24). At most one entry may match a request.
- R3: An entry matches only when its secure tag equals `lk_ns_i`.
- R4: An entry matches only when its global flag is set or its address-space tag equals the current one. The current tag is loaded by `ctx_wr_i`.
- R5: On a hit, `pa_o` is the entry's physical address bits [31:N] joined to the request's virtual address bits [N-1:0].
- R6: On a hit, an abort is raised in three cases: a user access to a privileged-only entry; a write to a read-only entry on the data side; any fetch from a no-execute entry on the instruction side. `abort_pf_o` carries it when `IS_INSTR`=1, otherwise `abort_dat_o` carries it, and `hit_o` and `pa_o` stay valid.
- R7: A write of `ctx_wr_i` or a pulse on `maint_i` invalidates every entry. A refill in the same cycle is dropped. The new address-space tag applies from the next request.
- R8: A miss drives `miss_va_o` with the virtual address of the request.
- R9: A refill takes the lowest-numbered empty slot, or, when all slots are full, slots in round-robin order starting at 0 after reset or a flush. The new entry can be hit by a request in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_ns_i | input | 1 | Request is non-secure |
| lk_user_i | input | 1 | Request is from user mode |
| lk_write_i | input | 1 | Request is a write |
| ctx_wr_i | input | 1 | Context register write (flushes) |
| ctx_asid_i | input | 8 | New current address-space tag |
| maint_i | input | 1 | Backing-store maintenance (flushes) |
| fill_i | input | 1 | Refill write |
| fill_vtag_i | input | 20 | Refill virtual page bits [31:12] |
| fill_ptag_i | input | 20 | Refill physical page bits [31:12] |
| fill_size_i | input | 2 | Refill page size code |
| fill_asid_i | input | 8 | Refill address-space tag |
| fill_global_i | input | 1 | Refill entry is global |
| fill_ns_i | input | 1 | Refill entry is non-secure |
| fill_priv_i | input | 1 | Refill entry is privileged-only |
| fill_ro_i | input | 1 | Refill entry is read-only |
| fill_xn_i | input | 1 | Refill entry is no-execute |
| hit_o | output | 1 | Lookup hit |
| pa_o | output | 32 | Translated physical address |
| miss_o | output | 1 | Lookup miss / refill request |
| miss_va_o | output | 32 | Virtual address to refill |
| abort_pf_o | output | 1 | Prefetch-kind abort |
| abort_dat_o | output | 1 | Data-kind abort |

## Verification
For every page size, the bench flips each address bit one at a time. A design with the size mask off by one nibble would then hit on a flipped bit it should compare, or miss on one it should ignore. On each hit the bench also checks the physical address, which catches a design that joins the offset at the wrong boundary. The bench fills past capacity to check the eviction order, and it fills in the same cycle as a flush, where a design that gave the refill priority would keep a stale entry. It also runs lookups that differ only in secure tag or address-space tag, and access kinds against each permission bit, to catch a dropped match term or an abort on the wrong output.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    localparam int VA_W   = 32;
    localparam int PG_LSB = 12;
    localparam int TAG_W  = VA_W - PG_LSB;
    localparam int ASID_W = 8;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic priv_only;
        logic read_only;
        logic no_exec;
    } perm_t;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  vtag;
        logic [TAG_W-1:0]  ptag;
        pg_size_e          size;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic              ns;
        perm_t             perm;
    } entry_t;

    // ones on the page-number bits that take part in the compare
    function automatic logic [TAG_W-1:0] keep_mask(pg_size_e s);
        logic [TAG_W-1:0] m;
        case (s)
            PG_4K:   m = {TAG_W{1'b1}};
            PG_64K:  m = {{(TAG_W-4){1'b1}}, 4'h0};
            PG_1M:   m = {{(TAG_W-8){1'b1}}, 8'h00};
            default: m = {{(TAG_W-12){1'b1}}, 12'h000};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/utlb_sel.sv
module utlb_sel #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // lowest set bit wins
    always_comb begin
        idx_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end
    assign any_o = |vec_i;
endmodule

// File: rtl/utlb_cmp.sv
module utlb_cmp
    import utlb_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  entry_t [DEPTH-1:0] ent_i,
    input  logic [TAG_W-1:0]   vtag_i,
    input  logic               ns_i,
    input  logic [ASID_W-1:0]  asid_i,
    output logic [DEPTH-1:0]   hit_vec_o
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_way
        logic [TAG_W-1:0] m;
        logic             va_eq, ns_eq, as_eq;
        assign m     = keep_mask(ent_i[g].size);
        assign va_eq = ((ent_i[g].vtag ^ vtag_i) & m) == '0;
        assign ns_eq = ent_i[g].ns == ns_i;
        assign as_eq = ent_i[g].glob || (ent_i[g].asid == asid_i);
        assign hit_vec_o[g] = ent_i[g].valid && va_eq && ns_eq && as_eq;
    end
endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] valid_i,
    input  logic [IDX_W-1:0] rr_i,
    output logic             full_o,
    output logic [IDX_W-1:0] idx_o
);
    logic             has_free;
    logic [IDX_W-1:0] free_idx;

    utlb_sel #(.DEPTH(DEPTH)) free_sel_i (
        .vec_i (~valid_i),
        .any_o (has_free),
        .idx_o (free_idx)
    );

    assign full_o = !has_free;
    assign idx_o  = has_free ? free_idx : rr_i;
endmodule

// File: rtl/utlb_top.sv
module utlb_top
    import utlb_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter bit IS_INSTR = 1'b0,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lk_valid_i,
    input  logic [VA_W-1:0]   lk_va_i,
    input  logic              lk_ns_i,
    input  logic              lk_user_i,
    input  logic              lk_write_i,
    input  logic              ctx_wr_i,
    input  logic [ASID_W-1:0] ctx_asid_i,
    input  logic              maint_i,
    input  logic              fill_i,
    input  logic [TAG_W-1:0]  fill_vtag_i,
    input  logic [TAG_W-1:0]  fill_ptag_i,
    input  logic [1:0]        fill_size_i,
    input  logic [ASID_W-1:0] fill_asid_i,
    input  logic              fill_global_i,
    input  logic              fill_ns_i,
    input  logic              fill_priv_i,
    input  logic              fill_ro_i,
    input  logic              fill_xn_i,
    output logic              hit_o,
    output logic [VA_W-1:0]   pa_o,
    output logic              miss_o,
    output logic [VA_W-1:0]   miss_va_o,
    output logic              abort_pf_o,
    output logic              abort_dat_o
);

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic [IDX_W-1:0]   rr;
        logic [ASID_W-1:0]  asid;
        logic               hit;
        logic               miss;
        logic [VA_W-1:0]    pa;
        logic [VA_W-1:0]    miss_va;
        logic               abort;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH-1:0] hit_vec;
    logic [DEPTH-1:0] valid_vec;
    logic             any_hit;
    logic [IDX_W-1:0] hit_idx;
    logic             full;
    logic [IDX_W-1:0] vic_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_valid
        assign valid_vec[g] = st_q.ent[g].valid;
    end

    utlb_cmp #(.DEPTH(DEPTH)) cmp_i (
        .ent_i     (st_q.ent),
        .vtag_i    (lk_va_i[VA_W-1:PG_LSB]),
        .ns_i      (lk_ns_i),
        .asid_i    (st_q.asid),
        .hit_vec_o (hit_vec)
    );

    utlb_sel #(.DEPTH(DEPTH)) hit_sel_i (
        .vec_i (hit_vec),
        .any_o (any_hit),
        .idx_o (hit_idx)
    );

    utlb_victim #(.DEPTH(DEPTH)) vic_i (
        .valid_i (valid_vec),
        .rr_i    (st_q.rr),
        .full_o  (full),
        .idx_o   (vic_idx)
    );

    always_comb begin
        entry_t           sel;
        entry_t           nw;
        logic [TAG_W-1:0] m;
        logic             viol;

        st_d    = st_q;
        sel     = st_q.ent[hit_idx];
        m       = keep_mask(sel.size);
        viol    = 1'b0;

        // lookup result, registered
        st_d.hit     = lk_valid_i && any_hit;
        st_d.miss    = lk_valid_i && !any_hit;
        st_d.miss_va = (lk_valid_i && !any_hit) ? lk_va_i : '0;
        st_d.pa      = '0;
        if (lk_valid_i && any_hit) begin
            st_d.pa = {(sel.ptag & m) | (lk_va_i[VA_W-1:PG_LSB] & ~m),
                       lk_va_i[PG_LSB-1:0]};
            if (sel.perm.priv_only && lk_user_i) viol = 1'b1;
            if (IS_INSTR) begin
                if (sel.perm.no_exec) viol = 1'b1;
            end else begin
                if (sel.perm.read_only && lk_write_i) viol = 1'b1;
            end
        end
        st_d.abort = viol;

        // refill
        nw.valid          = 1'b1;
        nw.vtag           = fill_vtag_i;
        nw.ptag           = fill_ptag_i;
        nw.size           = pg_size_e'(fill_size_i);
        nw.asid           = fill_asid_i;
        nw.glob           = fill_global_i;
        nw.ns             = fill_ns_i;
        nw.perm.priv_only = fill_priv_i;
        nw.perm.read_only = fill_ro_i;
        nw.perm.no_exec   = fill_xn_i;
        if (fill_i) begin
            st_d.ent[vic_idx] = nw;
            if (full) begin
                st_d.rr = (st_q.rr == IDX_W'(DEPTH - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end

        // flush has priority over a refill
        if (maint_i || ctx_wr_i) begin
            for (int i = 0; i < DEPTH; i++) st_d.ent[i].valid = 1'b0;
            st_d.rr = '0;
        end
        if (ctx_wr_i) st_d.asid = ctx_asid_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o       = st_q.hit;
    assign miss_o      = st_q.miss;
    assign pa_o        = st_q.pa;
    assign miss_va_o   = st_q.miss_va;
    assign abort_pf_o  = IS_INSTR ? st_q.abort : 1'b0;
    assign abort_dat_o = IS_INSTR ? 1'b0 : st_q.abort;

endmodule

// File: rtl/utlb_chk.sv
module utlb_chk #(
    parameter int DEPTH = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             lk_valid_i,
    input logic             ctx_wr_i,
    input logic             maint_i,
    input logic             fill_i,
    input logic [DEPTH-1:0] hit_vec,
    input logic [DEPTH-1:0] valid_vec,
    input logic             hit_o,
    input logic             miss_o,
    input logic             abort_pf_o,
    input logic             abort_dat_o
);
    a_r2_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_valid_i |-> $countones(hit_vec) <= 1);

    a_r1_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_valid_i |=> (hit_o != miss_o));

    a_r1_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lk_valid_i |=> (!hit_o && !miss_o));

    a_r6_abort_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (abort_pf_o || abort_dat_o) |-> hit_o);

    a_r6_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(abort_pf_o && abort_dat_o));

    a_r7_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (maint_i || ctx_wr_i) |=> (valid_vec == '0));

    a_r9_fill_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_i && !maint_i && !ctx_wr_i && !(&valid_vec))
        |=> $countones(valid_vec) == $countones($past(valid_vec)) + 1);
endmodule

bind utlb_top utlb_chk #(.DEPTH(DEPTH)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_valid_i  (lk_valid_i),
    .ctx_wr_i    (ctx_wr_i),
    .maint_i     (maint_i),
    .fill_i      (fill_i),
    .hit_vec     (hit_vec),
    .valid_vec   (valid_vec),
    .hit_o       (hit_o),
    .miss_o      (miss_o),
    .abort_pf_o  (abort_pf_o),
    .abort_dat_o (abort_dat_o)
);

// File: tb/utlb_top_tb.sv
module utlb_top_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_ns = 0, lk_user = 0, lk_write = 0;
    logic [31:0] lk_va = '0;
    logic        ctx_wr = 0, maint = 0, fill = 0;
    logic [7:0]  ctx_asid = '0, f_asid = '0;
    logic [19:0] f_vtag = '0, f_ptag = '0;
    logic [1:0]  f_size = '0;
    logic        f_glob = 0, f_ns = 0, f_priv = 0, f_ro = 0, f_xn = 0;

    logic        hit, miss, ab_pf, ab_dat;
    logic [31:0] pa, miss_va;
    logic        hit2, miss2, ab_pf2, ab_dat2;
    logic [31:0] pa2, miss_va2;

    int checks = 0;
    int fails  = 0;

    always #2ns clk = ~clk;

    utlb_top #(.DEPTH(D), .IS_INSTR(1'b0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .lk_valid_i(lk_valid), .lk_va_i(lk_va),
        .lk_ns_i(lk_ns), .lk_user_i(lk_user), .lk_write_i(lk_write),
        .ctx_wr_i(ctx_wr), .ctx_asid_i(ctx_asid), .maint_i(maint), .fill_i(fill),
        .fill_vtag_i(f_vtag), .fill_ptag_i(f_ptag), .fill_size_i(f_size),
        .fill_asid_i(f_asid), .fill_global_i(f_glob), .fill_ns_i(f_ns),
        .fill_priv_i(f_priv), .fill_ro_i(f_ro), .fill_xn_i(f_xn),
        .hit_o(hit), .pa_o(pa), .miss_o(miss), .miss_va_o(miss_va),
        .abort_pf_o(ab_pf), .abort_dat_o(ab_dat));

    utlb_top #(.DEPTH(4), .IS_INSTR(1'b1)) dut_pf_i (
        .clk_i(clk), .rst_ni(rst_n), .lk_valid_i(lk_valid), .lk_va_i(lk_va),
        .lk_ns_i(lk_ns), .lk_user_i(lk_user), .lk_write_i(lk_write),
        .ctx_wr_i(ctx_wr), .ctx_asid_i(ctx_asid), .maint_i(maint), .fill_i(fill),
        .fill_vtag_i(f_vtag), .fill_ptag_i(f_ptag), .fill_size_i(f_size),
        .fill_asid_i(f_asid), .fill_global_i(f_glob), .fill_ns_i(f_ns),
        .fill_priv_i(f_priv), .fill_ro_i(f_ro), .fill_xn_i(f_xn),
        .hit_o(hit2), .pa_o(pa2), .miss_o(miss2), .miss_va_o(miss_va2),
        .abort_pf_o(ab_pf2), .abort_dat_o(ab_dat2));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic lookup(input logic [31:0] va, input logic ns, input logic user, input logic wr);
        lk_valid = 1; lk_va = va; lk_ns = ns; lk_user = user; lk_write = wr;
        @(posedge clk); @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic put(input logic [31:0] va, input logic [31:0] pa_in, input logic [1:0] sz,
                       input logic [7:0] asid, input logic glob, input logic ns,
                       input logic priv, input logic ro, input logic xn);
        fill = 1; f_vtag = va[31:12]; f_ptag = pa_in[31:12]; f_size = sz; f_asid = asid;
        f_glob = glob; f_ns = ns; f_priv = priv; f_ro = ro; f_xn = xn;
        @(posedge clk); @(negedge clk);
        fill = 0;
    endtask

    task automatic flush();
        maint = 1;
        @(posedge clk); @(negedge clk);
        maint = 0;
    endtask

    initial begin
        #(200000 * 4ns);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] base_va, base_pa;
        base_va = 32'h1234_5678;
        base_pa = 32'hABCD_E000;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset hit", {31'd0, hit}, 0);
        check("R1 reset miss", {31'd0, miss}, 0);
        check("R6 reset abort", {30'd0, ab_pf, ab_dat}, 0);

        // R8 miss on empty array
        lookup(32'hDEAD_BEEF, 0, 0, 0);
        check("R8 miss flag", {31'd0, miss}, 1);
        check("R8 miss va", miss_va, 32'hDEAD_BEEF);
        check("R1 hit low on miss", {31'd0, hit}, 0);
        @(negedge clk);
        check("R1 idle quiet", {30'd0, hit, miss}, 0);

        // R2 / R5 size sweep with single-bit flips
        for (int s = 0; s < 4; s++) begin
            int n;
            n = 12 + 4 * s;
            flush();
            put(base_va, base_pa, 2'(s), 8'd0, 1, 0, 0, 0, 0);
            for (int k = 0; k <= 32; k++) begin
                logic [31:0] va, m;
                logic        exp_hit;
                va = (k == 32) ? base_va : base_va ^ (32'd1 << k);
                exp_hit = (k < n) || (k == 32);
                m = (32'd1 << n) - 1;
                lookup(va, 0, 0, 0);
                check($sformatf("R2 size %0d bit %0d hit", s, k), {31'd0, hit}, {31'd0, exp_hit});
                if (exp_hit)
                    check($sformatf("R5 size %0d bit %0d pa", s, k), pa, (base_pa & ~m) | (va & m));
            end
        end

        // R3 secure tag
        flush();
        put(32'h0040_0000, 32'h0800_0000, 2'd0, 8'd0, 1, 1, 0, 0, 0);
        lookup(32'h0040_0123, 0, 0, 0);
        check("R3 secure request misses ns entry", {31'd0, hit}, 0);
        lookup(32'h0040_0123, 1, 0, 0);
        check("R3 ns request hits", {31'd0, hit}, 1);
        check("R5 ns pa", pa, 32'h0800_0123);

        // R4 / R7 address-space tag
        ctx_asid = 8'd5; ctx_wr = 1;
        @(posedge clk); @(negedge clk);
        ctx_wr = 0;
        lookup(32'h0040_0123, 1, 0, 0);
        check("R7 ctx write flushed", {31'd0, miss}, 1);
        put(32'h0010_0000, 32'h0200_0000, 2'd0, 8'd5, 0, 0, 0, 0, 0);
        put(32'h0020_0000, 32'h0300_0000, 2'd0, 8'd7, 0, 0, 0, 0, 0);
        put(32'h0030_0000, 32'h0400_0000, 2'd0, 8'd7, 1, 0, 0, 0, 0);
        lookup(32'h0010_0004, 0, 0, 0);
        check("R4 matching tag hits", {31'd0, hit}, 1);
        lookup(32'h0020_0004, 0, 0, 0);
        check("R4 other tag misses", {31'd0, hit}, 0);
        lookup(32'h0030_0004, 0, 0, 0);
        check("R4 global hits", {31'd0, hit}, 1);

        // R7 maintenance flush, and flush beats same-cycle refill
        flush();
        lookup(32'h0010_0004, 0, 0, 0);
        check("R7 maint flushed", {31'd0, miss}, 1);
        maint = 1;
        put(32'h0050_0000, 32'h0500_0000, 2'd0, 8'd0, 1, 0, 0, 0, 0);
        maint = 0;
        lookup(32'h0050_0000, 0, 0, 0);
        check("R7 refill dropped under flush", {31'd0, hit}, 0);

        // R6 permissions
        flush();
        put(32'h0060_0000, 32'h0600_0000, 2'd0, 8'd0, 1, 0, 1, 0, 0);
        put(32'h0070_0000, 32'h0700_0000, 2'd0, 8'd0, 1, 0, 0, 1, 0);
        put(32'h0080_0000, 32'h0800_0000, 2'd0, 8'd0, 1, 0, 0, 0, 1);
        lookup(32'h0060_0010, 0, 1, 0);
        check("R6 user on priv aborts", {30'd0, ab_pf, ab_dat}, 1);
        check("R6 abort keeps hit", {31'd0, hit}, 1);
        check("R6 abort keeps pa", pa, 32'h0600_0010);
        check("R6 instr side user on priv", {30'd0, ab_pf2, ab_dat2}, 2);
        lookup(32'h0060_0010, 0, 0, 0);
        check("R6 priv on priv ok", {30'd0, ab_pf, ab_dat}, 0);
        lookup(32'h0070_0010, 0, 0, 1);
        check("R6 write to ro aborts", {30'd0, ab_pf, ab_dat}, 1);
        lookup(32'h0070_0010, 0, 0, 0);
        check("R6 read of ro ok", {30'd0, ab_pf, ab_dat}, 0);
        lookup(32'h0080_0010, 0, 0, 0);
        check("R6 xn no effect on data side", {30'd0, ab_pf, ab_dat}, 0);
        check("R6 xn fetch aborts instr side", {30'd0, ab_pf2, ab_dat2}, 2);

        // R9 fill order and round-robin eviction
        flush();
        for (int i = 0; i < D; i++)
            put(32'h1000_0000 + (i << 12), 32'h2000_0000 + (i << 12), 2'd0, 8'd0, 1, 0, 0, 0, 0);
        for (int i = 0; i < D; i++) begin
            lookup(32'h1000_0000 + (i << 12), 0, 0, 0);
            check($sformatf("R9 entry %0d held", i), {31'd0, hit}, 1);
        end
        put(32'h3000_0000, 32'h4000_0000, 2'd0, 8'd0, 1, 0, 0, 0, 0);
        lookup(32'h3000_0000, 0, 0, 0);
        check("R9 new entry visible next cycle", {31'd0, hit}, 1);
        lookup(32'h1000_0000, 0, 0, 0);
        check("R9 slot 0 evicted first", {31'd0, hit}, 0);
        lookup(32'h1000_1000, 0, 0, 0);
        check("R9 slot 1 kept", {31'd0, hit}, 1);
        put(32'h3000_1000, 32'h4000_1000, 2'd0, 8'd0, 1, 0, 0, 0, 0);
        lookup(32'h1000_1000, 0, 0, 0);
        check("R9 slot 1 evicted second", {31'd0, hit}, 0);
        lookup(32'h1000_2000, 0, 0, 0);
        check("R9 slot 2 kept", {31'd0, hit}, 1);
        lookup(32'h3000_0000, 0, 0, 0);
        check("R9 earlier refill kept", {31'd0, hit}, 1);

        finish_run();
    end
endmodule